// File: doc/BRIEF.md
# Dual-Clock Single-Bit FIFO with Programmable Thresholds

This block buffers a serial bit stream between two unrelated clocks. Bits enter on the rising edge of the write clock and leave through a registered output on the rising edge of the read clock. The depth is a power-of-two parameter (64, 256 or 512). Four active-low status outputs report the fill level. Full and almost-full are timed by the write clock. Empty and almost-empty are timed by the read clock.

The almost-empty offset n and the almost-full offset m can be programmed. Both start at 7. The level of `wr_en2_ld` while reset is held picks the personality of the block:

- **Two-enable personality:** the pin acts as a second write enable, which lets external logic steer words across several buffers.
- **Program personality:** the pin acts as a strobe that feeds the program byte into a rotating set of four offset byte registers.

An output-valid qualifier takes the place of a three-state output control.

Top module: `sbit_async_fifo`

## Requirements
- R1: While `rst` is high (sampled on each clock), the block resets. Both pointers return to location zero, `full_n` and `afull_n` go to 1, `empty_n` and `aempty_n` go to 0, `dout` clears to 0, and both offsets return to 7.
- R2: The value of `wr_en2_ld` on the last write-clock edge with `rst` high sets the personality. 1 selects two-enable; 0 selects program. The personality does not change again until the next reset.
- R3: A word is written on a rising `wclk` edge when `wr_en1_n`=0 and `wr_en2_ld`=1. The write is ignored while `full_n`=0. With `wr_en1_n`=1 nothing is written.
- R4: On a rising `rclk` edge with `rd_en_n`=0 and `empty_n`=1, the oldest word moves into `dout`. Otherwise `dout` keeps its value. A read while `empty_n`=0 is ignored.
- R5: Words leave in exactly the order they were accepted, with no loss and no duplication, under any mix of clock ratios and enable patterns.
- R6: `full_n` is 0 exactly when DEPTH words are held. It falls at the write edge that stores the last word.
- R7: `empty_n` is 0 when no word is held. It falls at the read edge that removes the last word. A write reaches the read side through Gray-coded pointers and a two-stage synchroniser, so `empty_n` may rise a few read cycles later.
- R8: Once settled, `aempty_n` is 0 for a count from 0 to n and 1 for a count of n+1 or more.
- R9: Once settled, `afull_n` is 0 for a count from DEPTH-m to DEPTH and 1 below DEPTH-m.
- R10: In the program personality, an edge with `wr_en1_n`=0 and `wr_en2_ld`=0 stores `prog_data` into the next byte slot and writes no word. The slot order is empty-low, empty-high, full-low, full-high, and the fifth such edge returns to empty-low. Each offset is the 16-bit value {high,low} modulo DEPTH.
- R11: Raising `wr_en2_ld` part-way through the slot sequence pauses it. The next load continues at the following slot.
- R12: In the two-enable personality, `wr_en2_ld`=0 blocks writes and never changes an offset.
- R13: `dout_vld` equals the inverse of `out_en_n` as sampled on the previous rising `rclk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Synchronous reset, active high, applied in both domains |
| din | input | 1 | Serial data in |
| wr_en1_n | input | 1 | Primary write enable, active low |
| wr_en2_ld | input | 1 | Second write enable or offset-load strobe (active low), chosen at reset |
| prog_data | input | 8 | Offset byte to load |
| rd_en_n | input | 1 | Read enable, active low |
| out_en_n | input | 1 | Output qualifier request, active low |
| dout | output | 1 | Registered serial data out |
| dout_vld | output | 1 | Output qualifier |
| full_n | output | 1 | Full, active low, write domain |
| afull_n | output | 1 | Almost full, active low, write domain |
| empty_n | output | 1 | Empty, active low, read domain |
| aempty_n | output | 1 | Almost empty, active low, read domain |

## Verification
Directed fills and drains with the other side idle check each flag edge at the exact cycle. This separates the boundary count DEPTH-m-1 from DEPTH-m, n from n+1, and DEPTH-1 from DEPTH. Offset loads with a pause, a non-zero high byte and a fifth wrapping load show whether the slot sequencer rotates, resumes and truncates correctly. Random traffic runs on coprime clocks in three modes: write-heavy, read-heavy and balanced. It keeps the buffer pinned against full, against empty and in between, which exposes pointer-crossing and gating faults through data order. A second reset into the two-enable personality shows that the strobe no longer touches the offsets.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  // Order of the offset byte slots; the sequencer walks it and wraps.
  typedef enum logic [1:0] {
    SLOT_EMPTY_LO = 2'd0,
    SLOT_EMPTY_HI = 2'd1,
    SLOT_FULL_LO  = 2'd2,
    SLOT_FULL_HI  = 2'd3
  } ofs_slot_e;

  localparam int OFS_W = 16;
endpackage

// File: rtl/sbf_gray_sync.sv
module sbf_gray_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [STAGES-1:0][W-1:0] stg;
  logic [W-1:0]             g_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= gray_in;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign g_last = stg[STAGES-1];

  always_comb begin
    for (int i = 0; i < W; i++) bin_out[i] = ^(g_last >> i);
  end
endmodule

// File: rtl/sbf_mem.sv
module sbf_mem #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic          rclk,
  input  logic          rst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);
  logic ram [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rst)     rdata <= 1'b0;
    else if (re) rdata <= ram[raddr];
  end

  AST_DOUT_HOLD: assert property (@(posedge rclk) disable iff (rst) !re |=> $stable(rdata)); // R4
endmodule

// File: rtl/sbf_wr_ctl.sv
module sbf_wr_ctl
  import sbf_pkg::*;
#(
  parameter int               DEPTH   = 64,
  parameter int               AW      = 6,
  parameter int               PW      = 7,
  parameter logic [OFS_W-1:0] OFS_DEF = 16'd7
) (
  input  logic             wclk,
  input  logic             rst,
  input  logic             wr_en1_n,
  input  logic             wr_en2_ld,
  input  logic [7:0]       prog_data,
  input  logic [PW-1:0]    rptr_bin_s,
  output logic             mem_we,
  output logic [AW-1:0]    mem_waddr,
  output logic [PW-1:0]    wptr_gray,
  output logic             full_n,
  output logic             afull_n,
  output logic [OFS_W-1:0] empty_ofs
);
  localparam logic [PW-1:0]    DEPTH_P  = PW'(DEPTH);
  localparam logic [OFS_W-1:0] OFS_MASK = OFS_W'(DEPTH - 1);
  localparam logic [OFS_W-1:0] DEPTH_O  = OFS_W'(DEPTH);

  logic             two_we_mode;
  logic [PW-1:0]    wptr, wptr_nxt, cnt_nxt;
  logic [OFS_W-1:0] full_ofs, full_m;
  ofs_slot_e        slot;
  logic             wr_req, ld_req, wr_go;

  assign wr_req    = !wr_en1_n && wr_en2_ld;
  assign ld_req    = !wr_en1_n && !wr_en2_ld && !two_we_mode;
  assign wr_go     = wr_req && full_n && !rst;
  assign wptr_nxt  = wptr + PW'(wr_go);
  assign cnt_nxt   = wptr_nxt - rptr_bin_s;
  assign full_m    = full_ofs & OFS_MASK;
  assign mem_we    = wr_go;
  assign mem_waddr = wptr[AW-1:0];

  always_ff @(posedge wclk) begin
    if (rst) begin
      two_we_mode <= wr_en2_ld;
      wptr        <= '0;
      wptr_gray   <= '0;
      full_n      <= 1'b1;
      afull_n     <= 1'b1;
    end else begin
      wptr      <= wptr_nxt;
      wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
      full_n    <= (cnt_nxt != DEPTH_P);
      afull_n   <= ((OFS_W'(cnt_nxt) + full_m) < DEPTH_O);
    end
  end

  always_ff @(posedge wclk) begin
    if (rst) begin
      empty_ofs <= OFS_DEF;
      full_ofs  <= OFS_DEF;
      slot      <= SLOT_EMPTY_LO;
    end else if (ld_req) begin
      unique case (slot)
        SLOT_EMPTY_LO: empty_ofs[7:0]  <= prog_data;
        SLOT_EMPTY_HI: empty_ofs[15:8] <= prog_data;
        SLOT_FULL_LO:  full_ofs[7:0]   <= prog_data;
        SLOT_FULL_HI:  full_ofs[15:8]  <= prog_data;
      endcase
      slot <= ofs_slot_e'(slot + 2'd1);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (rst)
    (wptr - rptr_bin_s) <= DEPTH_P); // R3
  AST_FULL_SAFE: assert property (@(posedge wclk) disable iff (rst)
    full_n |-> ((wptr - rptr_bin_s) != DEPTH_P)); // R6
  AST_WGRAY_STEP: assert property (@(posedge wclk) disable iff (rst)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1); // R7
  AST_MODE_HOLD: assert property (@(posedge wclk) disable iff (rst)
    1'b1 |=> $stable(two_we_mode)); // R2
endmodule

// File: rtl/sbf_rd_ctl.sv
module sbf_rd_ctl
  import sbf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int PW    = 7
) (
  input  logic             rclk,
  input  logic             rst,
  input  logic             rd_en_n,
  input  logic             out_en_n,
  input  logic [PW-1:0]    wptr_bin_s,
  input  logic [OFS_W-1:0] empty_ofs,
  output logic             mem_re,
  output logic [AW-1:0]    mem_raddr,
  output logic [PW-1:0]    rptr_gray,
  output logic             empty_n,
  output logic             aempty_n,
  output logic             dout_vld
);
  localparam logic [PW-1:0]    DEPTH_P  = PW'(DEPTH);
  localparam logic [OFS_W-1:0] OFS_MASK = OFS_W'(DEPTH - 1);

  logic [PW-1:0]    rptr, rptr_nxt, cnt_nxt;
  logic [OFS_W-1:0] empty_n_ofs;
  logic             rd_go;

  assign rd_go       = !rd_en_n && empty_n && !rst;
  assign rptr_nxt    = rptr + PW'(rd_go);
  assign cnt_nxt     = wptr_bin_s - rptr_nxt;
  assign empty_n_ofs = empty_ofs & OFS_MASK;
  assign mem_re      = rd_go;
  assign mem_raddr   = rptr[AW-1:0];

  always_ff @(posedge rclk) begin
    if (rst) begin
      rptr      <= '0;
      rptr_gray <= '0;
      empty_n   <= 1'b0;
      aempty_n  <= 1'b0;
      dout_vld  <= 1'b0;
    end else begin
      rptr      <= rptr_nxt;
      rptr_gray <= rptr_nxt ^ (rptr_nxt >> 1);
      empty_n   <= (cnt_nxt != '0);
      aempty_n  <= (OFS_W'(cnt_nxt) > empty_n_ofs);
      dout_vld  <= !out_en_n;
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (rst)
    (wptr_bin_s - rptr) <= DEPTH_P); // R4
  AST_EMPTY_SAFE: assert property (@(posedge rclk) disable iff (rst)
    empty_n |-> ((wptr_bin_s - rptr) != '0)); // R7
  AST_RGRAY_STEP: assert property (@(posedge rclk) disable iff (rst)
    $countones(rptr_gray ^ $past(rptr_gray)) <= 1); // R7
endmodule

// File: rtl/sbit_async_fifo.sv
module sbit_async_fifo
  import sbf_pkg::*;
#(
  parameter int               DEPTH       = 64,
  parameter int               SYNC_STAGES = 2,
  parameter logic [OFS_W-1:0] OFS_DEF     = 16'd7
) (
  input  logic       wclk,
  input  logic       rclk,
  input  logic       rst,
  input  logic       din,
  input  logic       wr_en1_n,
  input  logic       wr_en2_ld,
  input  logic [7:0] prog_data,
  input  logic       rd_en_n,
  input  logic       out_en_n,
  output logic       dout,
  output logic       dout_vld,
  output logic       full_n,
  output logic       afull_n,
  output logic       empty_n,
  output logic       aempty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic             mem_we, mem_re;
  logic [AW-1:0]    mem_waddr, mem_raddr;
  logic [PW-1:0]    wptr_gray, rptr_gray, wptr_bin_s, rptr_bin_s;
  logic [OFS_W-1:0] empty_ofs;

  sbf_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .OFS_DEF(OFS_DEF)) wr_ctl_i (
    .wclk(wclk), .rst(rst), .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld),
    .prog_data(prog_data), .rptr_bin_s(rptr_bin_s), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .wptr_gray(wptr_gray), .full_n(full_n),
    .afull_n(afull_n), .empty_ofs(empty_ofs)
  );

  sbf_rd_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) rd_ctl_i (
    .rclk(rclk), .rst(rst), .rd_en_n(rd_en_n), .out_en_n(out_en_n),
    .wptr_bin_s(wptr_bin_s), .empty_ofs(empty_ofs), .mem_re(mem_re),
    .mem_raddr(mem_raddr), .rptr_gray(rptr_gray), .empty_n(empty_n),
    .aempty_n(aempty_n), .dout_vld(dout_vld)
  );

  sbf_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) w2r_sync_i (
    .clk(rclk), .rst(rst), .gray_in(wptr_gray), .bin_out(wptr_bin_s)
  );

  sbf_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) r2w_sync_i (
    .clk(wclk), .rst(rst), .gray_in(rptr_gray), .bin_out(rptr_bin_s)
  );

  sbf_mem #(.DEPTH(DEPTH), .AW(AW)) mem_i (
    .wclk(wclk), .we(mem_we), .waddr(mem_waddr), .wdata(din),
    .rclk(rclk), .rst(rst), .re(mem_re), .raddr(mem_raddr), .rdata(dout)
  );
endmodule

// File: tb/sbit_async_fifo_tb.sv
`timescale 1ns/1ps
module sbit_async_fifo_tb_top;
  localparam int DEPTH = 64;

  logic wclk = 1'b0;
  logic rclk = 1'b0;
  always #4   wclk = ~wclk;   // 125 MHz
  always #5.5 rclk = ~rclk;   // 11 ns, coprime with 8 ns

  logic       rst = 1'b1, din = 1'b0, wr_en1_n = 1'b1, wr_en2_ld = 1'b1;
  logic [7:0] prog_data = 8'h00;
  logic       rd_en_n = 1'b1, out_en_n = 1'b1;
  logic       dout, dout_vld, full_n, afull_n, empty_n, aempty_n;

  sbit_async_fifo #(.DEPTH(DEPTH)) dut_i (
    .wclk(wclk), .rclk(rclk), .rst(rst), .din(din), .wr_en1_n(wr_en1_n),
    .wr_en2_ld(wr_en2_ld), .prog_data(prog_data), .rd_en_n(rd_en_n),
    .out_en_n(out_en_n), .dout(dout), .dout_vld(dout_vld), .full_n(full_n),
    .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  bit         q[$];
  int         n_cmp = 0, n_bad = 0, slot = 0;
  logic [7:0] ofs_b[4];
  bit         prog_mode = 1'b1, done = 1'b0;
  logic       exp_dout = 1'b0;

  function automatic int ofs_val(logic [7:0] lo, logic [7:0] hi);
    return int'({hi, lo}) % DEPTH;
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset(bit two_we);
    rst = 1'b1; wr_en2_ld = two_we; wr_en1_n = 1'b1; rd_en_n = 1'b1;
    repeat (4) @(negedge wclk);
    repeat (4) @(negedge rclk);
    @(negedge wclk);
    rst = 1'b0; wr_en2_ld = 1'b1;
    repeat (3) @(negedge rclk);
    q.delete();
    ofs_b = '{8'd7, 8'd0, 8'd7, 8'd0};
    slot = 0; prog_mode = !two_we; exp_dout = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (6) @(negedge wclk);
  endtask

  task automatic check_flags(string req);
    int c = q.size();
    int n = ofs_val(ofs_b[0], ofs_b[1]);
    int m = ofs_val(ofs_b[2], ofs_b[3]);
    chk(req, "empty_n",  empty_n,  c != 0);
    chk(req, "full_n",   full_n,   c != DEPTH);
    chk(req, "aempty_n", aempty_n, c > n);
    chk(req, "afull_n",  afull_n,  c < DEPTH - m);
  endtask

  task automatic do_write(logic d);
    @(negedge wclk);
    wr_en1_n = 1'b0; wr_en2_ld = 1'b1; din = d;
    if (full_n) q.push_back(d);
    @(negedge wclk);
    wr_en1_n = 1'b1;
  endtask

  task automatic do_read(string req);
    @(negedge rclk);
    rd_en_n = 1'b0;
    if (empty_n) exp_dout = q.pop_front();
    @(negedge rclk);
    rd_en_n = 1'b1;
    chk(req, "dout", dout, exp_dout);
  endtask

  task automatic do_load(logic [7:0] p);
    @(negedge wclk);
    wr_en1_n = 1'b0; wr_en2_ld = 1'b0; prog_data = p;
    if (prog_mode) begin
      ofs_b[slot] = p;
      slot = (slot + 1) % 4;
    end
    @(negedge wclk);
    wr_en1_n = 1'b1; wr_en2_ld = 1'b1;
  endtask

  task automatic drain(string req);
    while (q.size() > 0) do_read(req);
    chk("R7", "empty_n", empty_n, 1'b0);
  endtask

  task automatic rand_phase(int cycles, int wr_pct, int rd_pct);
    fork
      begin
        repeat (cycles) begin
          @(negedge wclk);
          din = 1'($urandom);
          wr_en2_ld = 1'b1;
          wr_en1_n = !(int'($urandom % 100) < wr_pct);
          if (!wr_en1_n && full_n) q.push_back(din);
        end
        @(negedge wclk);
        wr_en1_n = 1'b1;
      end
      begin
        bit pend = 1'b0;
        repeat ((cycles * 8) / 11) begin
          @(negedge rclk);
          if (pend) chk("R5", "dout", dout, exp_dout);
          rd_en_n = !(int'($urandom % 100) < rd_pct);
          pend = !rd_en_n && empty_n;
          if (pend) begin
            if (q.size() == 0) begin
              n_cmp++; n_bad++;
              $display("FAIL R4 read: actual empty_n 1 expected 0 with model empty");
              pend = 1'b0;
            end else begin
              exp_dout = q.pop_front();
            end
          end
        end
        @(negedge rclk);
        rd_en_n = 1'b1;
        if (pend) chk("R5", "dout", dout, exp_dout);
      end
    join
    settle();
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240));
    ofs_b = '{8'd7, 8'd0, 8'd7, 8'd0};

    // Program personality, reset state
    do_reset(1'b0);
    chk("R1", "empty_n", empty_n, 1'b0);
    chk("R1", "full_n", full_n, 1'b1);
    chk("R1", "aempty_n", aempty_n, 1'b0);
    chk("R1", "afull_n", afull_n, 1'b1);
    chk("R1", "dout", dout, 1'b0);
    chk("R13", "dout_vld", dout_vld, 1'b0);

    // Default n = 7: count 7 still almost empty, 8 not
    for (int i = 0; i < 7; i++) do_write(1'(i % 3 == 0));
    settle();
    check_flags("R1 R8");
    do_write(1'b1);
    settle();
    check_flags("R8");
    for (int i = 0; i < 8; i++) begin
      do_read("R5");
      if (i == 6) chk("R7", "empty_n", empty_n, 1'b1);
    end
    chk("R7", "empty_n", empty_n, 1'b0);
    do_read("R4");                          // read while empty: dout holds

    // Offsets with a pause and a non-zero high byte (n=3, m=5)
    do_load(8'd3);
    repeat (3) @(negedge wclk);
    do_load(8'hA5);
    do_load(8'd5);
    repeat (2) @(negedge wclk);
    do_load(8'h3C);
    settle();
    check_flags("R10");
    for (int i = 0; i < 3; i++) do_write(1'(i));
    settle();
    check_flags("R11");
    do_write(1'b1);
    settle();
    check_flags("R11");
    while (q.size() < 58) do_write(1'($urandom));
    chk("R9", "afull_n", afull_n, 1'b1);
    do_write(1'b0);
    chk("R9", "afull_n", afull_n, 1'b0);
    while (q.size() < 63) do_write(1'($urandom));
    chk("R6", "full_n", full_n, 1'b1);
    do_write(1'b1);
    chk("R6", "full_n", full_n, 1'b0);
    do_write(1'b0);                         // overrun must be dropped
    do_write(1'b1);
    settle();
    check_flags("R3");
    drain("R3");

    // Fifth load wraps to empty-low (n=9, m=2)
    do_load(8'd1); do_load(8'd0); do_load(8'd2); do_load(8'd0); do_load(8'd9);
    for (int i = 0; i < 9; i++) do_write(1'(i % 2));
    settle();
    check_flags("R10");
    do_write(1'b1);
    settle();
    check_flags("R10");
    drain("R5");

    // Random traffic: write-heavy, read-heavy, balanced
    rand_phase(2000, 80, 30);
    check_flags("R6");
    rand_phase(2000, 30, 80);
    check_flags("R8");
    rand_phase(1500, 50, 50);
    check_flags("R9");
    drain("R5");

    // Two-enable personality: strobe low blocks writes and loads nothing
    do_reset(1'b1);
    do_load(8'd1); do_load(8'd1); do_load(8'd1);
    settle();
    chk("R12", "empty_n", empty_n, 1'b0);
    repeat (4) begin
      @(negedge wclk);
      wr_en1_n = 1'b1; wr_en2_ld = 1'b1; din = 1'b1;
    end
    settle();
    chk("R3", "empty_n", empty_n, 1'b0);
    for (int i = 0; i < 7; i++) do_write(1'(i % 2));
    settle();
    check_flags("R12");
    do_write(1'b0);
    settle();
    check_flags("R2");
    while (q.size() < 56) do_write(1'($urandom));
    chk("R9", "afull_n", afull_n, 1'b1);
    do_write(1'b1);
    chk("R9", "afull_n", afull_n, 1'b0);
    drain("R5");

    // Output qualifier
    @(negedge rclk); out_en_n = 1'b0;
    @(negedge rclk); chk("R13", "dout_vld", dout_vld, 1'b1);
    out_en_n = 1'b1;
    @(negedge rclk); chk("R13", "dout_vld", dout_vld, 1'b0);

    finish_run();
  end
endmodule